// File: doc/BRIEF.md
# Dual-Timebase Capture/Compare Array

This block provides two 16-bit up-counting time bases, each with a reload value, and an array of capture/compare channels. Each channel has one input pin and one output pin. Each channel can follow either time base. A channel either records the time of a pin edge or compares its register with its time base. On a match it acts according to the compare flavour it is set to: it raises an interrupt request, toggles its pin, or sets its pin once per period. An even channel can also be joined with the odd channel above it, so that both registers steer one pin.

A time base advances on one of three sources. The first is a binary-divided system clock, from divide-by-8 to divide-by-1024. The second is a tick input that is qualified each cycle. The third, for time base 0 only, is the rising edges of an external count pin. When a time base wraps past its all-ones value it loads its reload value and pulses an overflow request. Software reaches every register through a single write strobe and a combinational read port.

Top module: `capcom_array`

## Requirements
- R1: After reset all output pins, channel requests and overflow requests are 0, and every register reads 0. The address map is: counts at 0 and 2, reloads at 1 and 3, control at 4, channel c value at 16+c and channel c mode at 32+c.
- R2: Each tick adds one to the count. A tick at 0xFFFF instead loads the reload value and raises that time base's bit of `tmr_irq` for exactly one cycle, in the cycle in which the new count is visible.
- R3: Control bits [5:0] configure time base 0 and bits [13:8] configure time base 1. Within each field, bit 0 is run, bits 3:1 are ps and bits 5:4 are the source. Source 0 ticks once every 8<<ps clocks. Source 1 ticks in every clock in which `alt_tick_i` is high. Source 2 ticks on each rising edge of `t0_cnt_in`, and only for time base 0. Source 3, or run=0, stops the count.
- R4: Mode bits [2:0]=1 select capture. Mode bits [5:4] select the edges: bit 4 for rising, bit 5 for falling. On a selected edge of the channel's input pin, the channel stores the selected timer's count and raises its request one cycle later.
- R5: Kind 2 raises the channel request on every match, including repeated matches inside one period.
- R6: Kind 3 toggles the pin and raises the request on every match.
- R7: Kind 4 raises the request only on the first match after the most recent overflow of its timer or after a mode write.
- R8: Kind 5 drives the pin to 1 and raises the request on the first match per period. It drives the pin to 0 on its timer's overflow. If both happen in one cycle, the set wins.
- R9: Mode bit 6 on an even channel c pairs it with channel c+1. Pin c then toggles on a match of either register, and each channel raises its own request. The kind fields of both channels are ignored, and pin c+1 holds.
- R10: Mode bit 3 selects the time base used for the compare or the capture: 0 for time base 0, 1 for time base 1.
- R11: Kinds 0, 1, 2 and 4 never change the pin. Kind 0 never raises a request. A match is only taken in the cycle after the time base was stepped by a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pin_in | input | NCH | Channel input pins (synchronous) |
| pin_out | output | NCH | Channel output pins |
| t0_cnt_in | input | 1 | External count pin for time base 0 |
| alt_tick_i | input | 1 | Alternate tick source |
| ch_irq | output | NCH | Per-channel request pulses |
| tmr_irq | output | 2 | Per-timer overflow pulses |

## Verification
The bench sweeps every channel through every compare kind on both time bases. In the middle of a period it rewinds the count. A design that locked kind 2 would then lose the second request, and one that forgot to lock kind 4 or 5 would raise it twice. Overflow cases check the clear of kind 5, and a reload value equal to the compare value checks that the set wins. A design that mixed up the time-base select would match the idle timer parked at 0x1000 and miss the real one. Prescaler spacing is measured for every divider, and the paired mode is checked for pin c+1 holding while pin c toggles twice per period.

// File: rtl/capcom_pkg.sv
package capcom_pkg;
    localparam logic [1:0] SRC_PRESC = 2'd0;
    localparam logic [1:0] SRC_ALT   = 2'd1;
    localparam logic [1:0] SRC_CNTIN = 2'd2;

    localparam logic [2:0] K_OFF      = 3'd0;
    localparam logic [2:0] K_CAP      = 3'd1;
    localparam logic [2:0] K_CMP_IRQ  = 3'd2;
    localparam logic [2:0] K_CMP_TGL  = 3'd3;
    localparam logic [2:0] K_CMP_IRQ1 = 3'd4;
    localparam logic [2:0] K_CMP_SET1 = 3'd5;

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] ps;
        logic       run;
    } tmr_cfg_t;

    typedef struct packed {
        logic       pair;
        logic [1:0] edg;
        logic       tsel;
        logic [2:0] kind;
    } ch_mode_t;
endpackage

// File: rtl/capcom_prescaler.sv
module capcom_prescaler
    import capcom_pkg::*;
#(
    parameter int PS_W    = 3,
    parameter int BASE_SH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tmr_cfg_t [1:0] cfg,
    input  logic           alt_tick_i,
    input  logic           cnt_in_i,
    output logic [1:0]     tick
);
    localparam int DIV_W = BASE_SH + (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cin_prev;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W-1:0] mask;
    logic             src_tick;

    always_comb begin
        st_d          = st_q;
        st_d.div      = st_q.div + 1'b1;
        st_d.cin_prev = cnt_in_i;
        mask          = '0;
        src_tick      = 1'b0;
        for (int k = 0; k < 2; k++) begin
            mask = DIV_W'((32'd1 << (BASE_SH + 32'(cfg[k].ps))) - 32'd1);
            unique case (cfg[k].src)
                SRC_PRESC: src_tick = ((st_q.div & mask) == mask);
                SRC_ALT:   src_tick = alt_tick_i;
                SRC_CNTIN: src_tick = (k == 0) && cnt_in_i && !st_q.cin_prev;
                default:   src_tick = 1'b0;
            endcase
            tick[k] = cfg[k].run && src_tick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < 2; k++) begin : g_chk
        AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[k] && cfg[k].src == SRC_PRESC) |=> !(tick[k] && cfg[k].src == SRC_PRESC)); // R3
    end
endmodule

// File: rtl/capcom_timer.sv
module capcom_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_cnt,
    input  logic          wr_rld,
    input  logic [TW-1:0] wdata,
    output logic [TW-1:0] cnt_o,
    output logic [TW-1:0] rld_o,
    output logic          step_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] rld;
        logic          step;
        logic          ovf;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        st_d.ovf  = 1'b0;
        if (tick) begin
            st_d.step = 1'b1;
            if (&st_q.cnt) begin
                st_d.cnt = st_q.rld;
                st_d.ovf = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (wr_cnt) begin
            st_d.cnt  = wdata;
            st_d.step = 1'b0;
            st_d.ovf  = 1'b0;
        end
        if (wr_rld) st_d.rld = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign rld_o  = st_q.rld;
    assign step_o = st_q.step;
    assign ovf_o  = st_q.ovf;

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&cnt_o) && !wr_cnt) |=> (cnt_o == $past(rld_o)) && ovf_o && step_o); // R2
    AST_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(&cnt_o) && !wr_cnt) |=> (cnt_o == $past(cnt_o) + 1'b1) && !ovf_o); // R2
endmodule

// File: rtl/capcom_channel.sv
module capcom_channel
    import capcom_pkg::*;
#(
    parameter int TW      = 16,
    parameter bit IS_EVEN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_val,
    input  logic          wr_mode,
    input  logic [TW-1:0] wdata,
    input  logic [TW-1:0] t0_val,
    input  logic [TW-1:0] t1_val,
    input  logic [1:0]    step,
    input  logic [1:0]    ovf,
    input  logic          pin_i,
    input  logic          partner_match_i,
    input  logic          paired_i,
    output logic [TW-1:0] val_o,
    output ch_mode_t      mode_o,
    output logic          match_o,
    output logic          irq_o,
    output logic          pin_o
);
    typedef struct packed {
        logic [TW-1:0] val;
        ch_mode_t      mode;
        logic          done;
        logic          pin;
        logic          irq;
        logic          pin_prev;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic [TW-1:0] tval;
    logic tstep, tovf, dbl, cmp_on, hit, rise, fall, locked, cap_evt;

    always_comb begin
        tval    = st_q.mode.tsel ? t1_val : t0_val;
        tstep   = step[st_q.mode.tsel];
        tovf    = ovf[st_q.mode.tsel];
        dbl     = IS_EVEN && st_q.mode.pair;
        cmp_on  = dbl || paired_i || (st_q.mode.kind inside {K_CMP_IRQ, K_CMP_TGL, K_CMP_IRQ1, K_CMP_SET1});
        hit     = cmp_on && tstep && (tval == st_q.val);
        rise    = pin_i && !st_q.pin_prev;
        fall    = !pin_i && st_q.pin_prev;
        cap_evt = (rise && st_q.mode.edg[0]) || (fall && st_q.mode.edg[1]);
        locked  = st_q.done && !tovf;

        st_d          = st_q;
        st_d.irq      = 1'b0;
        st_d.pin_prev = pin_i;
        if (tovf) st_d.done = 1'b0;

        if (dbl) begin
            if (hit || partner_match_i) st_d.pin = ~st_q.pin;
            st_d.irq = hit;
        end else if (paired_i) begin
            st_d.irq = hit;
        end else begin
            unique case (st_q.mode.kind)
                K_CAP: if (cap_evt) begin
                    st_d.val = tval;
                    st_d.irq = 1'b1;
                end
                K_CMP_IRQ: st_d.irq = hit;
                K_CMP_TGL: begin
                    st_d.irq = hit;
                    if (hit) st_d.pin = ~st_q.pin;
                end
                K_CMP_IRQ1: if (hit && !locked) begin
                    st_d.irq  = 1'b1;
                    st_d.done = 1'b1;
                end
                K_CMP_SET1: begin
                    if (tovf) st_d.pin = 1'b0;
                    if (hit && !locked) begin
                        st_d.irq  = 1'b1;
                        st_d.done = 1'b1;
                        st_d.pin  = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (wr_val) st_d.val = wdata;
        if (wr_mode) begin
            st_d.mode = ch_mode_t'(wdata[6:0]);
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o   = st_q.val;
    assign mode_o  = st_q.mode;
    assign match_o = hit;
    assign irq_o   = st_q.irq;
    assign pin_o   = st_q.pin;

    AST_ONCE_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !tovf && !wr_mode && !dbl && !paired_i &&
         (mode_o.kind == K_CMP_IRQ1 || mode_o.kind == K_CMP_SET1)) |=> !irq_o); // R7
    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && mode_o.kind != K_CMP_TGL && mode_o.kind != K_CMP_SET1) |=> $stable(pin_o)); // R11
    AST_OVF_CLEARS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && !paired_i && mode_o.kind == K_CMP_SET1 && tovf && !hit) |=> !pin_o); // R8
    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && !paired_i && mode_o.kind == K_CAP && cap_evt && !wr_val) |=> (val_o == $past(tval)) && irq_o); // R4
endmodule

// File: rtl/capcom_array.sv
module capcom_array
    import capcom_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int TW      = 16,
    parameter int PS_W    = 3,
    parameter int BASE_SH = 3,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [TW-1:0]     rd_data,
    input  logic [NCH-1:0]    pin_in,
    output logic [NCH-1:0]    pin_out,
    input  logic              t0_cnt_in,
    input  logic              alt_tick_i,
    output logic [NCH-1:0]    ch_irq,
    output logic [1:0]        tmr_irq
);
    localparam int A_CTL       = 4;
    localparam int A_VAL_BASE  = 16;
    localparam int A_MODE_BASE = 32;
    localparam int CFG_W       = $bits(tmr_cfg_t);
    localparam int CFG_SLOT    = 8;

    typedef struct packed {
        tmr_cfg_t [1:0] cfg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [1:0]    tick, t_step, t_ovf;
    logic [TW-1:0] t_cnt [2];
    logic [TW-1:0] t_rld [2];
    logic [TW-1:0] ch_val [NCH];
    ch_mode_t      ch_mode [NCH];
    logic [NCH-1:0] ch_match, partner, paired;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_addr == ADDR_W'(A_CTL)) begin
            st_d.cfg[0] = tmr_cfg_t'(wr_data[CFG_W-1:0]);
            st_d.cfg[1] = tmr_cfg_t'(wr_data[CFG_SLOT+CFG_W-1:CFG_SLOT]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    capcom_prescaler #(.PS_W(PS_W), .BASE_SH(BASE_SH)) i_presc (
        .clk(clk), .rst_n(rst_n), .cfg(st_q.cfg), .alt_tick_i(alt_tick_i),
        .cnt_in_i(t0_cnt_in), .tick(tick)
    );

    for (genvar k = 0; k < 2; k++) begin : g_tmr
        capcom_timer #(.TW(TW)) i_tmr (
            .clk(clk), .rst_n(rst_n), .tick(tick[k]),
            .wr_cnt(wr_en && wr_addr == ADDR_W'(2 * k)),
            .wr_rld(wr_en && wr_addr == ADDR_W'(2 * k + 1)),
            .wdata(wr_data), .cnt_o(t_cnt[k]), .rld_o(t_rld[k]),
            .step_o(t_step[k]), .ovf_o(t_ovf[k])
        );
    end
    assign tmr_irq = t_ovf;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if ((c % 2) == 0 && (c + 1) < NCH) begin : g_even
            assign partner[c] = ch_match[c+1];
            assign paired[c]  = 1'b0;
        end else if ((c % 2) == 1) begin : g_odd
            assign partner[c] = 1'b0;
            assign paired[c]  = ch_mode[c-1].pair;
        end else begin : g_last
            assign partner[c] = 1'b0;
            assign paired[c]  = 1'b0;
        end

        capcom_channel #(.TW(TW), .IS_EVEN((c % 2) == 0)) i_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_val(wr_en && wr_addr == ADDR_W'(A_VAL_BASE + c)),
            .wr_mode(wr_en && wr_addr == ADDR_W'(A_MODE_BASE + c)),
            .wdata(wr_data), .t0_val(t_cnt[0]), .t1_val(t_cnt[1]),
            .step(t_step), .ovf(t_ovf), .pin_i(pin_in[c]),
            .partner_match_i(partner[c]), .paired_i(paired[c]),
            .val_o(ch_val[c]), .mode_o(ch_mode[c]), .match_o(ch_match[c]),
            .irq_o(ch_irq[c]), .pin_o(pin_out[c])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < 2; k++) begin
            if (rd_addr == ADDR_W'(2 * k))     rd_data = t_cnt[k];
            if (rd_addr == ADDR_W'(2 * k + 1)) rd_data = t_rld[k];
        end
        if (rd_addr == ADDR_W'(A_CTL))
            rd_data = TW'({2'b00, st_q.cfg[1], 2'b00, st_q.cfg[0]});
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == ADDR_W'(A_VAL_BASE + c))  rd_data = ch_val[c];
            if (rd_addr == ADDR_W'(A_MODE_BASE + c)) rd_data = TW'(ch_mode[c]);
        end
    end
endmodule

// File: tb/test_capcom_array.sv
module test_capcom_array;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_addr = '0;
    logic [15:0]     wr_data = '0;
    logic [5:0]      rd_addr = '0;
    logic [15:0]     rd_data;
    logic [NCH-1:0]  pin_in = '0;
    logic [NCH-1:0]  pin_out;
    logic            t0_cnt_in = 1'b0;
    logic            alt_tick_i = 1'b0;
    logic [NCH-1:0]  ch_irq;
    logic [1:0]      tmr_irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [NCH-1:0] exp_pin = '0;

    always #10 clk = ~clk;

    capcom_array #(.NCH(NCH)) i_capcom_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .t0_cnt_in(t0_cnt_in), .alt_tick_i(alt_tick_i), .ch_irq(ch_irq), .tmr_irq(tmr_irq)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        rd_addr = 6'(a);
        #1;
        d = rd_data;
    endtask

    task automatic step();
        alt_tick_i = 1'b1;
        cyc();
        alt_tick_i = 1'b0;
    endtask

    task automatic clear_modes();
        for (int j = 0; j < NCH; j++) wr(32 + j, 16'h0000);
    endtask

    // sweep one compare kind on one channel and one time base
    task automatic run_cmp(input int c, input int kind, input int s);
        logic [15:0] v, rv;
        logic ovf, hit, locked, done, irq;
        string tag;
        int o;
        o = 1 - s;
        tag = (kind == 2) ? "R5 R10" : (kind == 3) ? "R6 R10" : (kind == 4) ? "R7 R10" : "R8 R10";
        clear_modes();
        wr(16 + c, 16'hFFFA);
        wr(2 * s, 16'hFFF8); wr(2 * s + 1, 16'hFFF8);
        wr(2 * o, 16'h1000); wr(2 * o + 1, 16'h1000);
        wr(32 + c, 16'(kind | (s << 3)));
        v = 16'hFFF8; done = 1'b0;
        for (int n = 0; n < 24; n++) begin
            if (n == 4) begin
                wr(2 * s, 16'hFFF9);
                v = 16'hFFF9;
            end
            step();
            ovf = (v == 16'hFFFF);
            v = ovf ? 16'hFFF8 : v + 16'd1;
            hit = (v == 16'hFFFA);
            check("R2 overflow request", {30'd0, tmr_irq}, ovf ? (32'd1 << s) : 32'd0);
            locked = done && !ovf;
            if (ovf) done = 1'b0;
            irq = 1'b0;
            case (kind)
                2: irq = hit;
                3: begin irq = hit; if (hit) exp_pin[c] = ~exp_pin[c]; end
                4: begin irq = hit && !locked; if (irq) done = 1'b1; end
                default: begin
                    if (ovf) exp_pin[c] = 1'b0;
                    irq = hit && !locked;
                    if (irq) begin done = 1'b1; exp_pin[c] = 1'b1; end
                end
            endcase
            cyc();
            check({tag, " channel request"}, {31'd0, ch_irq[c]}, {31'd0, irq});
            check("R11 idle channels silent", 32'(ch_irq & ~(4'b1 << c)), 32'd0);
            check({tag, " pins"}, 32'(pin_out), 32'(exp_pin));
        end
        rd(2 * o, rv);
        check("R10 unselected timer count", 32'(rv), 32'h1000 + 32'd24);
    endtask

    initial begin : main
        logic [15:0] rv, cv;
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 pins", 32'(pin_out), 32'd0);
        check("R1 requests", 32'({ch_irq, tmr_irq}), 32'd0);
        rd(4, rv);  check("R1 control", 32'(rv), 32'd0);
        rd(17, rv); check("R1 value", 32'(rv), 32'd0);
        rd(34, rv); check("R1 mode", 32'(rv), 32'd0);
        rd(3, rv);  check("R1 reload", 32'(rv), 32'd0);

        // R2 counting and wrap with reload
        wr(4, 16'h1111);
        wr(0, 16'hFFFD); wr(1, 16'h1234);
        rd(1, rv); check("R2 reload readback", 32'(rv), 32'h1234);
        step(); rd(0, rv); check("R2 count +1", 32'(rv), 32'hFFFE);
        check("R2 no overflow", 32'(tmr_irq), 32'd0);
        step(); rd(0, rv); check("R2 count +1", 32'(rv), 32'hFFFF);
        step(); rd(0, rv); check("R2 wrap loads reload", 32'(rv), 32'h1234);
        check("R2 overflow pulse", 32'(tmr_irq), 32'd1);
        cyc(); check("R2 pulse one cycle", 32'(tmr_irq), 32'd0);

        // R3 run bit off: no counting
        wr(4, 16'h1110);
        rd(0, cv);
        step(); step();
        rd(0, rv); check("R3 stopped timer holds", 32'(rv), 32'(cv));

        // R3 prescaler sweep on time base 1
        for (int ps = 0; ps < 8; ps++) begin
            wr(4, 16'((ps * 2 + 1) << 8));
            wr(2, 16'hFFFE); wr(3, 16'hFFFE);
            n = 0;
            while (!tmr_irq[1] && n < 5000) begin cyc(); n++; end
            n = 0;
            do begin cyc(); n++; end while (!tmr_irq[1] && n < 5000);
            check($sformatf("R3 divider ps=%0d period", ps), 32'(n), 32'(2 * (8 << ps)));
        end

        // R3 external count input on time base 0
        wr(4, 16'h0021);
        wr(0, 16'h0010);
        for (int p = 0; p < 5; p++) begin
            t0_cnt_in = 1'b1; cyc(); cyc();
            t0_cnt_in = 1'b0; cyc(); cyc();
        end
        t0_cnt_in = 1'b1; repeat (6) cyc();
        t0_cnt_in = 1'b0; cyc();
        rd(0, rv); check("R3 count-pin rising edges", 32'(rv), 32'h0016);

        // R5..R8, R10, R11 compare sweep
        wr(4, 16'h1111);
        for (int c = 0; c < NCH; c++)
            for (int kind = 2; kind <= 5; kind++)
                for (int s = 0; s < 2; s++)
                    run_cmp(c, kind, s);

        // R8 set wins over overflow clear when reload equals compare value
        clear_modes();
        wr(16, 16'hFFF0); wr(0, 16'hFFFF); wr(1, 16'hFFF0);
        wr(32, 16'h0005);
        step(); cyc();
        exp_pin[0] = 1'b1;
        check("R8 set wins at overflow", 32'(pin_out), 32'(exp_pin));

        // R4 capture with each edge selection
        wr(4, 16'h0000);
        for (int c = 0; c < NCH; c++) begin
            for (int e = 1; e <= 3; e++) begin
                int s;
                s = c & 1;
                clear_modes();
                wr(16 + c, 16'hDEAD);
                wr(2 * s, 16'(16'h1200 + c * 16 + e));
                wr(32 + c, 16'(1 | (s << 3) | (e << 4)));
                pin_in[c] = 1'b1; cyc();
                check("R4 rising request", 32'(ch_irq), (e & 1) ? (32'd1 << c) : 32'd0);
                rd(16 + c, rv);
                check("R4 rising value", 32'(rv), (e & 1) ? 32'(16'h1200 + c * 16 + e) : 32'hDEAD);
                cv = rv;
                wr(2 * s, 16'(16'h3400 + c * 16 + e));
                pin_in[c] = 1'b0; cyc();
                check("R4 falling request", 32'(ch_irq), (e & 2) ? (32'd1 << c) : 32'd0);
                rd(16 + c, rv);
                check("R4 falling value", 32'(rv), (e & 2) ? 32'(16'h3400 + c * 16 + e) : 32'(cv));
                check("R11 capture leaves pins", 32'(pin_out), 32'(exp_pin));
            end
        end

        // R9 paired registers on channels 0 and 1
        clear_modes();
        wr(4, 16'h1111);
        wr(0, 16'hFFF8); wr(1, 16'hFFF8);
        wr(16, 16'hFFF9); wr(17, 16'hFFFD);
        wr(33, 16'h0005);
        wr(32, 16'h0040);
        begin
            logic [15:0] v;
            logic h0, h1;
            v = 16'hFFF8;
            for (int k = 0; k < 16; k++) begin
                step();
                v = (v == 16'hFFFF) ? 16'hFFF8 : v + 16'd1;
                h0 = (v == 16'hFFF9); h1 = (v == 16'hFFFD);
                if (h0 || h1) exp_pin[0] = ~exp_pin[0];
                cyc();
                check("R9 paired requests", 32'(ch_irq), 32'({h1, h0}));
                check("R9 paired pins", 32'(pin_out), 32'(exp_pin));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule